// File: doc/BRIEF.md
# Event Frame Integrator

This block turns a stream of address-events into synchronous frames. Every event names one pixel by its column and row and adds one to that pixel's counter. Because each pixel reports its activity as an event rate, the count a pixel gathers over a fixed window stands for its intensity. When a window closes, the whole array of counts is streamed out in raster order, one pixel per clock, with a start flag on the first pixel. Each counter is cleared as it is read.

The block holds two count banks that take turns. One bank gathers events for the current window while the other is streamed out and cleared. The banks swap roles at every window boundary, so counting never stops: an event that arrives during a readout is added to the next frame. It is not lost and it is not counted twice. Each update is a read-modify-write, pipelined over two stages. When two events hit the same pixel on consecutive clocks, the newer event takes the pending value from the older one, so no increment is dropped. The window length is a cycle count taken from an input. The block samples that input only at a boundary.

Top module: `event_frame_integrator`

## Requirements
- R1: During reset and after it, `pixValid` is low until the first window closes. Reset clears both banks, so every pixel in the first frame that received no event reads zero.
- R2: Each event with `evValid` high adds exactly one to the counter at address `evY*2^X_BITS + evX` of the bank that is gathering.
- R3: A counter that holds `2^CNT_W-1` stays at that value on further events and never wraps.
- R4: Events to the same pixel on consecutive clock cycles are each counted.
- R5: The first window after reset lasts `DEF_PERIOD` cycles, counted from the first cycle with reset low. An event on the last cycle of a window belongs to that window. An event on the following cycle belongs to the next window.
- R6: Readout of a window begins 4 cycles after that window's last cycle. It emits one pixel per cycle, 2^(X_BITS+Y_BITS) pixels in all, in raster order with `pixX` changing fastest.
- R7: `pixSof` is high on the pixel (0, 0) of each frame and on no other pixel.
- R8: A pixel that is read out is cleared. When the same bank gathers again, a pixel that receives no event in that window reads zero.
- R9: `periodIn` is sampled only on the last cycle of a window and sets the length of the next window. A change in mid-window does not alter the current window.
- R10: A sampled `periodIn` below `2^(X_BITS+Y_BITS)+4` is raised to that minimum.
- R11: An event that arrives while the previous frame is being read out is counted in the next frame and not in the one being read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evValid | input | 1 | An event is present this cycle |
| evX | input | X_BITS | Column of the event |
| evY | input | Y_BITS | Row of the event |
| periodIn | input | PER_W | Window length in cycles, sampled at boundaries |
| pixValid | output | 1 | A readout pixel is on the outputs |
| pixSof | output | 1 | First pixel of a frame |
| pixX | output | X_BITS | Column of the readout pixel |
| pixY | output | Y_BITS | Row of the readout pixel |
| pixCount | output | CNT_W | Event count of the readout pixel |

## Verification
The hardest cases to reach from the ports sit around the window edge and inside the increment pipeline. One is an event on the very last cycle of a window, which must land in the bank that is about to be read. Another is a run of hits to a single pixel, where each increment must take the value still in flight. The stimulus table fills the first window with repeated and alternating addresses. Its longest run carries one pixel well past saturation. Further events are timed to the exact last cycle of a window, the cycle after it, and a cycle inside a readout. A long stream of changing addresses then crosses two boundaries. A model built from the requirements checks every pixel that leaves the block.

// File: rtl/efi_pkg.sv
package efi_pkg;
  // strobes handed from the control to the datapath each cycle
  typedef struct packed {
    logic accBank;  // bank that gathers new events
    logic rdEn;     // a readout pixel is fetched this cycle
  } efi_strobe_t;
endpackage

// File: rtl/efi_ctrl.sv
module efi_ctrl
  import efi_pkg::*;
#(
  parameter int PER_W      = 16,
  parameter int DEF_PERIOD = 4096,
  parameter int ADDR_W     = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PER_W-1:0]  periodIn,
  output efi_strobe_t       ctl,
  output logic [ADDR_W-1:0] rdAddr
);
  localparam int NPIX = 1 << ADDR_W;
  localparam logic [PER_W-1:0] MIN_P = PER_W'(NPIX + 4);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NPIX - 1);

  logic [PER_W-1:0] winCnt, curPeriod, nextPeriod;
  logic boundary, accBank, rdEn;
  logic [1:0] startPipe;

  assign boundary   = (winCnt == curPeriod - PER_W'(1));
  assign nextPeriod = (periodIn < MIN_P) ? MIN_P : periodIn;

  // window timer and bank toggle
  always_ff @(posedge clk) begin
    if (rst) begin
      winCnt    <= '0;
      curPeriod <= PER_W'(DEF_PERIOD);
      accBank   <= 1'b0;
    end else if (boundary) begin
      winCnt    <= '0;
      curPeriod <= nextPeriod;
      accBank   <= ~accBank;
    end else begin
      winCnt <= winCnt + PER_W'(1);
    end
  end

  // readout sequencer: waits for the in-flight increments to land
  always_ff @(posedge clk) begin
    if (rst) begin
      startPipe <= '0;
      rdEn      <= 1'b0;
      rdAddr    <= '0;
    end else begin
      startPipe <= {startPipe[0], boundary};
      if (startPipe[1]) begin
        rdEn   <= 1'b1;
        rdAddr <= '0;
      end else if (rdEn) begin
        if (rdAddr == LAST_ADDR) rdEn <= 1'b0;
        rdAddr <= rdAddr + ADDR_W'(1);
      end
    end
  end

  assign ctl.accBank = accBank;
  assign ctl.rdEn    = rdEn;

  // R6: readout of one bank completes before the next swap
  a_r6_read_before_swap: assert property (@(posedge clk) disable iff (rst)
    rdEn |-> !boundary);
  // R6: readout always starts at pixel zero
  a_r6_start_origin: assert property (@(posedge clk) disable iff (rst)
    $rose(rdEn) |-> rdAddr == '0);
  // R10: a loaded period never falls below the floor
  a_r10_period_floor: assert property (@(posedge clk) disable iff (rst)
    boundary |=> curPeriod >= MIN_P);
endmodule

// File: rtl/efi_datapath.sv
module efi_datapath
  import efi_pkg::*;
#(
  parameter int X_BITS = 5,
  parameter int Y_BITS = 5,
  parameter int CNT_W  = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  efi_strobe_t              ctl,
  input  logic [X_BITS+Y_BITS-1:0] rdAddr,
  input  logic                     evValid,
  input  logic [X_BITS-1:0]        evX,
  input  logic [Y_BITS-1:0]        evY,
  output logic                     pixValid,
  output logic                     pixSof,
  output logic [X_BITS-1:0]        pixX,
  output logic [Y_BITS-1:0]        pixY,
  output logic [CNT_W-1:0]         pixCount
);
  localparam int ADDR_W = X_BITS + Y_BITS;
  localparam int NPIX   = 1 << ADDR_W;
  localparam logic [CNT_W-1:0] MAXC = '1;

  logic rdBank;
  assign rdBank = ~ctl.accBank;

  // stage 1: captured event, bank tag, read of the current count
  logic              s1Valid, s1Bank;
  logic [ADDR_W-1:0] s1Addr;
  // stage 2: incremented count waiting to be written
  logic              s2Valid, s2Bank;
  logic [ADDR_W-1:0] s2Addr;
  logic [CNT_W-1:0]  s2Data;

  logic [CNT_W-1:0] accRead [2];
  logic [CNT_W-1:0] outRead [2];
  logic [CNT_W-1:0] s1Cur, s1Next;

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [CNT_W-1:0] mem [NPIX];
    always_ff @(posedge clk) begin
      if (rst) begin
        for (int i = 0; i < NPIX; i++) mem[i] <= '0;
      end else begin
        if (ctl.rdEn && rdBank == 1'(b)) mem[rdAddr] <= '0;
        if (s2Valid && s2Bank == 1'(b))  mem[s2Addr] <= s2Data;
      end
    end
    assign accRead[b] = mem[s1Addr];
    assign outRead[b] = mem[rdAddr];
  end

  // forward the pending write when stage 2 holds the same pixel
  assign s1Cur  = (s2Valid && s2Addr == s1Addr && s2Bank == s1Bank) ? s2Data
                                                                   : accRead[s1Bank];
  assign s1Next = (s1Cur == MAXC) ? MAXC : s1Cur + CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      s1Valid <= 1'b0;
      s1Bank  <= 1'b0;
      s1Addr  <= '0;
      s2Valid <= 1'b0;
      s2Bank  <= 1'b0;
      s2Addr  <= '0;
      s2Data  <= '0;
    end else begin
      s1Valid <= evValid;
      s1Bank  <= ctl.accBank;
      s1Addr  <= {evY, evX};
      s2Valid <= s1Valid;
      s2Bank  <= s1Bank;
      s2Addr  <= s1Addr;
      s2Data  <= s1Next;
    end
  end

  // registered pixel output
  always_ff @(posedge clk) begin
    if (rst) begin
      pixValid <= 1'b0;
      pixSof   <= 1'b0;
      pixX     <= '0;
      pixY     <= '0;
      pixCount <= '0;
    end else begin
      pixValid <= ctl.rdEn;
      pixSof   <= ctl.rdEn && (rdAddr == '0);
      pixX     <= rdAddr[X_BITS-1:0];
      pixY     <= rdAddr[ADDR_W-1:X_BITS];
      pixCount <= outRead[rdBank];
    end
  end

  // R11: gathering and readout never touch the same bank at once
  a_r11_banks_disjoint: assert property (@(posedge clk) disable iff (rst)
    (ctl.rdEn && s2Valid) |-> (s2Bank != rdBank));
  // R3: an increment never produces a wrapped zero
  a_r3_no_wrap: assert property (@(posedge clk) disable iff (rst)
    s2Valid |-> s2Data != '0);
  // R7: the start flag marks the origin pixel only
  a_r7_sof_origin: assert property (@(posedge clk) disable iff (rst)
    pixSof |-> (pixValid && pixX == '0 && pixY == '0));
endmodule

// File: rtl/event_frame_integrator.sv
module event_frame_integrator
  import efi_pkg::*;
#(
  parameter int X_BITS     = 5,
  parameter int Y_BITS     = 5,
  parameter int CNT_W      = 8,
  parameter int PER_W      = 16,
  parameter int DEF_PERIOD = 4096
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              evValid,
  input  logic [X_BITS-1:0] evX,
  input  logic [Y_BITS-1:0] evY,
  input  logic [PER_W-1:0]  periodIn,
  output logic              pixValid,
  output logic              pixSof,
  output logic [X_BITS-1:0] pixX,
  output logic [Y_BITS-1:0] pixY,
  output logic [CNT_W-1:0]  pixCount
);
  localparam int ADDR_W = X_BITS + Y_BITS;

  efi_strobe_t       ctl;
  logic [ADDR_W-1:0] rdAddr;

  efi_ctrl #(
    .PER_W(PER_W), .DEF_PERIOD(DEF_PERIOD), .ADDR_W(ADDR_W)
  ) ctrl_i (
    .clk(clk), .rst(rst), .periodIn(periodIn), .ctl(ctl), .rdAddr(rdAddr)
  );

  efi_datapath #(
    .X_BITS(X_BITS), .Y_BITS(Y_BITS), .CNT_W(CNT_W)
  ) dp_i (
    .clk(clk), .rst(rst), .ctl(ctl), .rdAddr(rdAddr),
    .evValid(evValid), .evX(evX), .evY(evY),
    .pixValid(pixValid), .pixSof(pixSof), .pixX(pixX), .pixY(pixY),
    .pixCount(pixCount)
  );
endmodule

// File: tb/event_frame_integrator_tb_top.sv
module event_frame_integrator_tb_top;
  localparam int XB = 3, YB = 3, CW = 4, PW = 16, DEFP = 100;
  localparam int NP = 1 << (XB + YB);
  localparam int MINP = NP + 4;
  localparam int MAXC = (1 << CW) - 1;
  localparam int NFR = 8;
  // stimulus table: x, y, repeats, idle cycles after, expected frame-0 count
  localparam int TBL_N = 8;
  localparam int TBL [TBL_N][5] = '{
    '{1, 0, 3, 1, 3},    // R4 back-to-back same pixel
    '{2, 3, 20, 1, 15},  // R3 saturation
    '{7, 7, 1, 0, 2},
    '{0, 0, 1, 0, 2},
    '{7, 7, 1, 0, 2},
    '{0, 0, 1, 2, 2},
    '{5, 1, 2, 0, 3},
    '{5, 1, 1, 3, 3}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic evValid = 1'b0;
  logic [XB-1:0] evX = '0;
  logic [YB-1:0] evY = '0;
  logic [PW-1:0] periodIn = PW'(70);
  logic pixValid, pixSof;
  logic [XB-1:0] pixX;
  logic [YB-1:0] pixY;
  logic [CW-1:0] pixCount;

  always #2 clk = ~clk;  // 250 MHz

  event_frame_integrator #(
    .X_BITS(XB), .Y_BITS(YB), .CNT_W(CW), .PER_W(PW), .DEF_PERIOD(DEFP)
  ) dut_i (
    .clk(clk), .rst(rst), .evValid(evValid), .evX(evX), .evY(evY),
    .periodIn(periodIn), .pixValid(pixValid), .pixSof(pixSof),
    .pixX(pixX), .pixY(pixY), .pixCount(pixCount)
  );

  int nChk = 0, nFail = 0;
  int cyc = 0;
  int curM [NP], doneM [NP];
  int mCnt = 0, mLen = DEFP;
  int frameBuf [NFR][NP];
  int sofCyc [NFR];
  int frIdx = 0, pixCtr = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // requirement model: windows, saturating counts, boundary hand-over
  always @(posedge clk) begin
    if (rst) begin
      cyc = 0; mCnt = 0; mLen = DEFP;
      for (int i = 0; i < NP; i++) begin curM[i] = 0; doneM[i] = 0; end
    end else begin
      cyc = cyc + 1;
      if (evValid && curM[int'(evY) * (1 << XB) + int'(evX)] < MAXC)
        curM[int'(evY) * (1 << XB) + int'(evX)] += 1;
      if (mCnt == mLen - 1) begin
        for (int i = 0; i < NP; i++) begin doneM[i] = curM[i]; curM[i] = 0; end
        mCnt = 0;
        mLen = (int'(periodIn) < MINP) ? MINP : int'(periodIn);
      end else begin
        mCnt = mCnt + 1;
      end
    end
  end

  // output monitor, sampled at the falling edge
  always @(negedge clk) begin
    if (rst) begin
      chk(pixValid == 1'b0, "R1 idle in reset", int'(pixValid), 0);
    end else if (pixValid) begin
      chk(int'(pixY) * (1 << XB) + int'(pixX) == pixCtr, "R6 raster order",
          int'(pixY) * (1 << XB) + int'(pixX), pixCtr);
      chk(pixSof == (pixCtr == 0), "R7 frame start flag", int'(pixSof), int'(pixCtr == 0));
      chk(int'(pixCount) == doneM[pixCtr], "R2/R3/R4/R8/R11 pixel count",
          int'(pixCount), doneM[pixCtr]);
      if (frIdx < NFR) begin
        frameBuf[frIdx][pixCtr] = int'(pixCount);
        if (pixSof) sofCyc[frIdx] = cyc;
      end
      if (pixCtr == NP - 1) begin pixCtr = 0; frIdx = frIdx + 1; end
      else pixCtr = pixCtr + 1;
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
  endtask

  task automatic waitCyc(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic oneEvent(input int x, input int y);
    evValid = 1'b1; evX = XB'(x); evY = YB'(y);
    @(negedge clk);
    evValid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 600);
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < NFR; i++) sofCyc[i] = -1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // window 0: walk the table from cycle 0
    for (int t = 0; t < TBL_N; t++) begin
      for (int r = 0; r < TBL[t][2]; r++) begin
        evValid = 1'b1; evX = XB'(TBL[t][0]); evY = YB'(TBL[t][1]);
        @(negedge clk);
      end
      evValid = 1'b0;
      repeat (TBL[t][3]) @(negedge clk);
    end
    chk(pixValid == 1'b0, "R1 no output before first boundary", int'(pixValid), 0);
    // R5: last cycle of window 0, then first cycle of window 1
    waitCyc(99);
    oneEvent(6, 6);
    oneEvent(6, 5);
    // R11: event during the readout of frame 0
    waitCyc(110);
    oneEvent(4, 4);
    // R9: change in mid-window
    waitCyc(130);
    periodIn = PW'(90);
    // R10: value below the floor
    waitCyc(200);
    periodIn = PW'(10);
    // stream across two boundaries
    waitCyc(300);
    while (cyc < 420) begin
      evValid = 1'b1; evX = XB'(cyc % 8); evY = YB'((cyc / 8) % 8);
      @(negedge clk);
    end
    evValid = 1'b0;
    waitCyc(545);

    // table results in frame 0
    for (int t = 0; t < TBL_N; t++)
      chk(frameBuf[0][TBL[t][1] * (1 << XB) + TBL[t][0]] == TBL[t][4],
          "R2/R3/R4 table pixel", frameBuf[0][TBL[t][1] * (1 << XB) + TBL[t][0]], TBL[t][4]);
    chk(frameBuf[0][5] == 0, "R1 untouched pixel zero", frameBuf[0][5], 0);
    chk(frameBuf[0][26] == MAXC, "R3 saturated pixel", frameBuf[0][26], MAXC);
    chk(frameBuf[0][1] == 3, "R4 back-to-back count", frameBuf[0][1], 3);
    chk(frameBuf[0][54] == 1, "R5 last-cycle event in ending window", frameBuf[0][54], 1);
    chk(frameBuf[0][46] == 0, "R5 next-cycle event not in ending window", frameBuf[0][46], 0);
    chk(frameBuf[1][46] == 1, "R5 next-cycle event in new window", frameBuf[1][46], 1);
    chk(frameBuf[0][36] == 0, "R11 readout-time event not in read frame", frameBuf[0][36], 0);
    chk(frameBuf[1][36] == 1, "R11 readout-time event in next frame", frameBuf[1][36], 1);
    chk(frameBuf[1][26] == 0, "R8 other bank empty", frameBuf[1][26], 0);
    chk(frameBuf[2][26] == 0, "R8 cleared after readout", frameBuf[2][26], 0);
    chk(sofCyc[0] == 103, "R6 readout start after first window", sofCyc[0], 103);
    chk(sofCyc[1] - sofCyc[0] == 70, "R9 period loaded at boundary", sofCyc[1] - sofCyc[0], 70);
    chk(sofCyc[2] - sofCyc[1] == 90, "R9 mid-window change deferred", sofCyc[2] - sofCyc[1], 90);
    chk(sofCyc[3] - sofCyc[2] == MINP, "R10 period floor", sofCyc[3] - sofCyc[2], MINP);
    chk(sofCyc[4] - sofCyc[3] == MINP, "R10 period floor held", sofCyc[4] - sofCyc[3], MINP);
    chk(frIdx == 6, "R6 frame count", frIdx, 6);
    summary();
    $finish;
  end
endmodule